// File: doc/BRIEF.md
# Dual-Output Power-Good Reset Timer

This block decides when a supervised pair of regulated outputs may let the system out of reset. It watches a digital "above trip point" flag for each of the two feedback nodes, the soft-start completion flag and two fault flags: undervoltage lockout and thermal shutdown. It drives a single output, `rst_pull`, that commands the pull-down transistor of an open-drain reset line. While `rst_pull` is high the line is held low. When `rst_pull` is low the line floats and an external resistor pulls it up.

The line stays low until three things hold at once: both outputs are good, soft-start has finished, and neither fault is present. It is then released only after a long timeout that runs without a break. The timeout length in clock cycles is derived from the `CLK_HZ` and `TIMEOUT_US` parameters. The two over-threshold flags come from asynchronous comparators, so each passes through a synchronizer of `SYNC_STAGES` flops, two by default. The fault flags are taken as synchronous and act on the next clock edge.

The control is a three-state machine:
- `ST_HOLD`: the line is pulled low.
- `ST_COUNT`: the line is still pulled low while the timer runs.
- `ST_RELEASE`: the line is released.

There are four named transitions:
- `t_arm` (HOLD to COUNT): all start conditions are met.
- `t_expire` (COUNT to RELEASE): the timer reaches its last cycle.
- `t_abort` (COUNT to HOLD): any start condition is lost. The timer is cleared.
- `t_drop` (RELEASE to HOLD): a good flag falls or a fault appears.

Top module: `pgr_reset_timer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `rst_pull` is 1.
- R2: `t_arm` needs both synchronized good flags high, `ss_done` high, and `uvlo` and `thermal` low. With the default two stages, a good flag that rises before clock edge k takes part in the decision at edge k+2. The machine therefore enters `ST_COUNT` at edge k+2, or at the next edge if the flags were already synchronized.
- R3: `rst_pull` falls exactly LIMIT clock edges after the edge that entered `ST_COUNT`, and stays 1 for every cycle before that. LIMIT = CLK_HZ*TIMEOUT_US/1e6.
- R4: While `ss_done` is low, `rst_pull` stays 1 for any length of time, even with both good flags high.
- R5: If a start condition is lost during `ST_COUNT`, the count is cleared. The next release then comes a full LIMIT edges after counting resumes, not at the original release time.
- R6: In `ST_RELEASE`, a good flag that falls before edge k makes `rst_pull` 1 after edge k+2, which is the third edge.
- R7: `uvlo` or `thermal` high before an edge sets `rst_pull` to 1 after that edge, from any state. While either is high, no counting takes place.
- R8: There is no hysteresis. A good flag held low for a single clock cycle is enough to abort or drop.
- R9: The output encoding is `rst_pull` = 1 to pull the line low and `rst_pull` = 0 to release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb1_ok | input | 1 | Output 1 above trip point (asynchronous) |
| fb2_ok | input | 1 | Output 2 above trip point (asynchronous) |
| ss_done | input | 1 | Soft-start complete |
| uvlo | input | 1 | Undervoltage lockout active |
| thermal | input | 1 | Thermal shutdown active |
| rst_pull | output | 1 | 1 = pull reset line low, 0 = release |

## Verification
A fault override and a good-flag drop can arrive in the same cycle. The fault acts one edge later, while the flag drop only arrives through the synchronizer two edges after that. The bench raises `thermal` and lowers `fb2_ok` in the same cycle while the line is released. It expects `rst_pull` high after the very next edge, which shows the fault path won. It then clears the fault while the flag is still low and expects no release until the flag returns and a full timeout has run. A one-cycle dip of one flag in the middle of a count is also provoked. The bench judges it by a release that is delayed to a full LIMIT after the restart.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_RELEASE = 2'd2
    } state_t;

    function automatic longint timeout_cycles(input longint hz, input longint us);
        longint c;
        c = (hz * us) / 64'd1000000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/pgr_sync.sv
module pgr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pgr_timer.sv
module pgr_timer #(
    parameter int LIMIT = 16,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (done) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/pgr_reset_timer.sv
module pgr_reset_timer #(
    parameter int CLK_HZ      = 1000000,
    parameter int TIMEOUT_US  = 315000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb1_ok,
    input  logic fb2_ok,
    input  logic ss_done,
    input  logic uvlo,
    input  logic thermal,
    output logic rst_pull
);
    import pgr_pkg::*;

    localparam longint LIMIT_L = timeout_cycles(longint'(CLK_HZ), longint'(TIMEOUT_US));
    localparam int     LIMIT   = int'(LIMIT_L);
    localparam int     CNT_W   = $clog2(LIMIT + 1);

    logic [1:0] ok_s;
    logic       tmr_done;
    logic       fault;
    logic       both_good;
    logic       arm;
    logic       run;
    state_t     state_q;
    state_t     state_d;

    pgr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({fb2_ok, fb1_ok}),
        .q    (ok_s)
    );

    assign fault     = uvlo | thermal;
    assign both_good = &ok_s;
    assign arm       = both_good & ss_done & ~fault;
    assign run       = (state_q == ST_COUNT) & arm;

    pgr_timer #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .done (tmr_done)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (arm) state_d = ST_COUNT;             // t_arm
            end
            ST_COUNT: begin
                if (!arm)          state_d = ST_HOLD;    // t_abort
                else if (tmr_done) state_d = ST_RELEASE; // t_expire
            end
            ST_RELEASE: begin
                if (fault || !both_good) state_d = ST_HOLD; // t_drop
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        rst_pull = (state_q != ST_RELEASE);
    end

endmodule

// File: rtl/pgr_reset_timer_chk.sv
module pgr_reset_timer_chk (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      ok_s,
    input logic            ss_done,
    input logic            uvlo,
    input logic            thermal,
    input pgr_pkg::state_t state,
    input logic            rst_pull,
    input logic            tmr_done
);
    import pgr_pkg::*;

    // R1
    reset_pull_chk: assert property (@(posedge clk)
        !rst_n |=> rst_pull);

    // R7
    fault_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo || thermal) |=> rst_pull);

    // R4
    hold_without_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !ss_done) |=> (state == ST_HOLD));

    // R2
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !(ok_s[0] && ok_s[1])) |=> (state == ST_HOLD));

    // R6
    drop_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pull && !(ok_s[0] && ok_s[1])) |=> rst_pull);

    // R3
    release_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull) |-> $past(state == ST_COUNT && tmr_done));

endmodule

bind pgr_reset_timer pgr_reset_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ok_s    (ok_s),
    .ss_done (ss_done),
    .uvlo    (uvlo),
    .thermal (thermal),
    .state   (state_q),
    .rst_pull(rst_pull),
    .tmr_done(tmr_done)
);

// File: tb/pgr_reset_timer_test.sv
module pgr_reset_timer_test;

    localparam int PERIOD = 10;
    localparam int LIMIT  = 40;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb1_ok = 1'b0, fb2_ok = 1'b0, ss_done = 1'b0, uvlo = 1'b0, thermal = 1'b0;
    logic rst_pull;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pgr_reset_timer #(.CLK_HZ(1000000), .TIMEOUT_US(LIMIT), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .fb1_ok(fb1_ok), .fb2_ok(fb2_ok),
        .ss_done(ss_done), .uvlo(uvlo), .thermal(thermal), .rst_pull(rst_pull)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver side: queue an expected rst_pull value dt cycles ahead
    task automatic expect_in(input int dt, input bit v, input string tag);
        exp_t e;
        int   pos;
        e.at = cyc + dt; e.val = v; e.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > e.at) begin pos = i; break; end
        end
        sb.insert(pos, e);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at < cyc) begin
                fails++;
                $display("FAIL %s: check at cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (rst_pull !== e.val) begin
                fails++;
                $display("FAIL %s: cycle %0d rst_pull=%0b expected %0b", e.tag, cyc, rst_pull, e.val);
            end
        end
    end

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_in(1, 1'b1, "R1 reset state");
        tick(2);

        // R4: good flags but no soft-start completion
        fb1_ok = 1'b1; fb2_ok = 1'b1;
        expect_in(LIMIT + 10, 1'b1, "R4 held without ss_done");
        tick(LIMIT + 12);

        // R2/R3: flags already synced, ss_done arms on next edge
        ss_done = 1'b1;
        expect_in(LIMIT,     1'b1, "R3 still pulled before timeout");
        expect_in(LIMIT + 1, 1'b0, "R2 R9 released after timeout");
        tick(LIMIT + 4);

        // R6: drop in release through the synchronizer
        fb1_ok = 1'b0;
        expect_in(2, 1'b0, "R6 still released two edges after drop");
        expect_in(3, 1'b1, "R6 pulled on third edge");
        tick(5);

        // R2/R5/R8: restart, then a one-cycle dip mid-count
        fb1_ok = 1'b1;
        expect_in(LIMIT + 2, 1'b1, "R2 count starts third edge");
        tick(20);
        fb2_ok = 1'b0;
        expect_in(LIMIT - 17, 1'b1, "R5 R8 original release cancelled");
        expect_in(LIMIT + 3,  1'b1, "R5 full count after restart");
        expect_in(LIMIT + 4,  1'b0, "R5 release after restart");
        tick(1);
        fb2_ok = 1'b1;
        tick(LIMIT + 8);

        // R7: undervoltage while released
        uvlo = 1'b1;
        expect_in(1, 1'b1, "R7 uvlo next edge");
        tick(3);
        uvlo = 1'b0;
        expect_in(LIMIT,     1'b1, "R7 recount after uvlo");
        expect_in(LIMIT + 1, 1'b0, "R7 release after uvlo");
        tick(LIMIT + 4);

        // R7: thermal while released, then again mid-count
        thermal = 1'b1;
        expect_in(1, 1'b1, "R7 thermal next edge");
        tick(2);
        thermal = 1'b0;
        tick(10);
        thermal = 1'b1;
        expect_in(LIMIT - 9, 1'b1, "R7 thermal aborts count");
        expect_in(LIMIT + 1, 1'b1, "R7 full recount after thermal");
        expect_in(LIMIT + 2, 1'b0, "R7 release after thermal");
        tick(1);
        thermal = 1'b0;
        tick(LIMIT + 6);

        // R7/R6: fault and flag drop in the same cycle
        thermal = 1'b1; fb2_ok = 1'b0;
        expect_in(1, 1'b1, "R7 fault wins same-cycle drop");
        tick(4);
        thermal = 1'b0;
        expect_in(LIMIT + 5, 1'b1, "R6 no release while flag low");
        tick(LIMIT + 6);
        fb2_ok = 1'b1;
        expect_in(LIMIT + 2, 1'b1, "R3 pulled until full count");
        expect_in(LIMIT + 3, 1'b0, "R3 R9 released after recovery");
        tick(LIMIT + 6);

        while (sb.size() > 0) tick(1);
        tick(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule